// File: doc/BRIEF.md
# LCD Contrast PWM Generator

This block drives one pulse-width-modulated line that sets the contrast of a display panel. A small register interface holds a control word and a duty value. The control word selects one of four clock divisions, the polarity of the output and whether the generator runs. An 8-bit counter advances once per divided tick. Over a period of 256 ticks the output is active while the counter is below the duty value.

A duty value written by software is held in a staging register. It is copied into the comparator only when the counter rolls over to zero, or at any time while the generator is stopped. A period that is already running is therefore never cut short or stretched. When the generator is stopped, the counter is cleared and the output rests at the inactive level for the selected polarity. The next enable starts a fresh period from count zero.

Top module: `lcd_contrast_pwm`

## Requirements
- R1: After reset the control word reads back as 0xF and the duty reads back as 0xC8. That is divide-by-8, positive polarity, enabled. With these values the output is active for 1600 of every 2048 clock cycles.
- R2: Register read-back is combinational. Address 0 returns the control word in bits [3:0] with the upper bits zero. Address 1 returns the last duty value written, even before it takes effect. Control bit 2 is polarity (1 = positive, 0 = negative) and control bit 3 is enable (1 = running). Control bits above 3 are ignored on write.
- R3: Control bits [1:0] select the clock division: 0 gives /1, 1 gives /2, 2 gives /4 and 3 gives /8. One period lasts 256×div clock cycles, and the output is active for duty×div cycles of each period.
- R4: With positive polarity the active level is high. With negative polarity the waveform is inverted and the active level is low.
- R5: While disabled, the output stays at the inactive level: low for positive polarity, high for negative. The counter is held at zero. After the enabling write, the output turns active one clock later, provided the duty is non-zero. Its first active run then lasts exactly duty×div cycles.
- R6: A duty value written in mid-period leaves the current period unchanged. The new value applies from the next rollover of the counter to zero.
- R7: A duty of 0 keeps the output inactive for the whole period. A duty of 255 makes it active for 255 of 256 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 duty |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read select: 0 control, 1 duty |
| rd_data | output | 8 | Read-back value |
| pwm_out | output | 1 | Contrast PWM output |

## Verification
The bench builds the block with its default parameters: an 8-bit counter and duty, a 2-bit division select, and reset values of divide-by-8, positive polarity, enabled and duty 0xC8. With these values the longest period is 2048 cycles. This lets the bench measure every division and both duty extremes over whole periods. It also lets the bench follow a single period cycle by cycle across an enable and a mid-period duty write.

// File: rtl/pwm_ctl_pkg.sv
package pwm_ctl_pkg;
  localparam int PS_W  = 2;
  localparam int DIV_W = (1 << PS_W) - 1;

  typedef struct packed {
    logic            run;
    logic            pos_pol;
    logic [PS_W-1:0] div_sel;
  } ctl_word_t;

  localparam int CTL_W = $bits(ctl_word_t);

  // last value of the tick divider counter for a given select
  function automatic logic [DIV_W-1:0] div_last(input logic [PS_W-1:0] sel);
    logic [DIV_W:0] one_hot;
    one_hot = '0;
    one_hot[sel] = 1'b1;
    return DIV_W'(one_hot - 1'b1);
  endfunction

  // output level from comparator result, polarity and run state
  function automatic logic drive_level(input logic below, input logic pos_pol,
                                       input logic run);
    if (!run) return ~pos_pol;
    return pos_pol ? below : ~below;
  endfunction
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_ctl_pkg::*;
#(
  parameter int          DUTY_W   = 8,
  parameter logic [CTL_W-1:0] RST_CTL = 4'hF,
  parameter logic [DUTY_W-1:0] RST_DUTY = 8'hC8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DUTY_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DUTY_W-1:0] rd_data,
  output ctl_word_t         ctl_o,
  output logic [DUTY_W-1:0] duty_stage_o
);
  localparam logic SEL_CTL  = 1'b0;
  localparam logic SEL_DUTY = 1'b1;

  ctl_word_t         ctl_q;
  logic [DUTY_W-1:0] duty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= ctl_word_t'(RST_CTL);
      duty_q <= RST_DUTY;
    end else if (wr_en) begin
      if (wr_addr == SEL_CTL) ctl_q  <= ctl_word_t'(wr_data[CTL_W-1:0]);
      else                    duty_q <= wr_data;
    end
  end

  always_comb begin
    if (rd_addr == SEL_CTL) rd_data = DUTY_W'(ctl_q);
    else                    rd_data = duty_q;
  end

  assign ctl_o        = ctl_q;
  assign duty_stage_o = duty_q;

  a_r2_duty_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == SEL_DUTY) |=> (duty_q == $past(wr_data)));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] div_sel,
  output logic            tick
);
  logic [DIV_W-1:0] div_cnt;

  // >= so that a select shrunk mid-count still yields a tick at once
  assign tick = run && (div_cnt >= div_last(div_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_cnt <= '0;
    else if (!run) div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + 1'b1;
  end

  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != '0) |=> (!tick || div_sel == '0));
endmodule

// File: rtl/pwm_engine.sv
module pwm_engine
  import pwm_ctl_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter logic [DUTY_W-1:0] RST_DUTY = 8'hC8,
  parameter logic RST_POL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              pos_pol,
  input  logic              tick,
  input  logic [DUTY_W-1:0] duty_stage,
  output logic              pwm_out,
  output logic              period_load
);
  localparam logic [DUTY_W-1:0] CNT_LAST = '1;

  logic [DUTY_W-1:0] cnt;
  logic [DUTY_W-1:0] duty_act;
  logic              below;
  logic              wrap_evt;

  assign wrap_evt    = tick && (cnt == CNT_LAST);
  assign period_load = !run || wrap_evt;
  assign below       = cnt < duty_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           duty_act <= RST_DUTY;
    else if (period_load) duty_act <= duty_stage;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_out <= ~RST_POL;
    else        pwm_out <= drive_level(below, pos_pol, run);
  end

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt == '0));
  a_r6_duty_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_act) |-> $past(period_load));
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run) |-> (pwm_out == !$past(pos_pol)));
  a_r5_count_held: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
  a_r7_zero_duty_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pos_pol && duty_act == '0) |=> !pwm_out);
  a_r7_zero_duty_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pos_pol && duty_act == '0) |=> pwm_out);
endmodule

// File: rtl/lcd_contrast_pwm.sv
module lcd_contrast_pwm
  import pwm_ctl_pkg::*;
#(
  parameter int DUTY_W = 8,
  parameter logic [CTL_W-1:0] RST_CTL = 4'hF,
  parameter logic [DUTY_W-1:0] RST_DUTY = 8'hC8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DUTY_W-1:0] wr_data,
  input  logic              rd_addr,
  output logic [DUTY_W-1:0] rd_data,
  output logic              pwm_out
);
  ctl_word_t         ctl;
  logic [DUTY_W-1:0] duty_stage;
  logic              tick;
  logic              period_load;

  pwm_regfile #(
    .DUTY_W(DUTY_W), .RST_CTL(RST_CTL), .RST_DUTY(RST_DUTY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ctl_o(ctl), .duty_stage_o(duty_stage)
  );

  pwm_prescaler u_div (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .div_sel(ctl.div_sel),
    .tick(tick)
  );

  pwm_engine #(
    .DUTY_W(DUTY_W), .RST_DUTY(RST_DUTY), .RST_POL(RST_CTL[2])
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .pos_pol(ctl.pos_pol),
    .tick(tick), .duty_stage(duty_stage), .pwm_out(pwm_out),
    .period_load(period_load)
  );

  a_r5_no_load_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.run && !tick) |-> !period_load);
endmodule

// File: tb/lcd_contrast_pwm_test.sv
module lcd_contrast_pwm_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       pwm_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  typedef struct {
    int    win;
    int    exp_active;
    logic  act_lvl;
    string tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int       sb_done = 0;

  lcd_contrast_pwm uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_check(input logic a, input int exp, input string tag);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(tag, int'(rd_data), exp);
  endtask

  // driver: queue one window measurement and wait for the monitor
  task automatic expect_window(input int win, input int exp_active,
                               input logic lvl, input string tag);
    sb_item_t it;
    int target;
    it.win = win; it.exp_active = exp_active; it.act_lvl = lvl; it.tag = tag;
    target = sb_done + 1;
    sb_q.push_back(it);
    wait (sb_done >= target);
  endtask

  task automatic settle(input int div);
    repeat (2 * 256 * div + 4) @(negedge clk);
  endtask

  // monitor: over any whole period the active count is fixed
  initial begin
    forever begin
      sb_item_t it;
      int cnt;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      cnt = 0;
      for (int i = 0; i < it.win; i++) begin
        @(negedge clk);
        if (pwm_out == it.act_lvl) cnt++;
      end
      check(it.tag, cnt, it.exp_active);
      sb_done++;
    end
  end

  function automatic logic [7:0] ctl(input int run, input int pos, input int sel);
    return 8'((run << 3) | (pos << 2) | sel);
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    int hi_run;
    int lo_run;
    int hi2_run;
    logic first_lvl;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values and default waveform
    read_check(1'b0, 'hF, "R1 reset control");
    read_check(1'b1, 'hC8, "R1 reset duty");
    settle(8);
    expect_window(2048, 1600, 1'b1, "R1 default waveform");

    // R2 read-back, upper control bits ignored, staged duty visible
    write_reg(1'b0, 8'hF5);
    read_check(1'b0, 'h5, "R2 control readback");
    write_reg(1'b1, 8'h3C);
    read_check(1'b1, 'h3C, "R2 duty readback");

    // R3 each division
    for (int s = 0; s < 4; s++) begin
      write_reg(1'b1, 8'd64);
      write_reg(1'b0, ctl(1, 1, s));
      settle(1 << s);
      expect_window(256 * (1 << s), 64 * (1 << s), 1'b1, $sformatf("R3 div sel %0d", s));
    end

    // R4 negative polarity: active level low
    write_reg(1'b1, 8'd100);
    write_reg(1'b0, ctl(1, 0, 1));
    settle(2);
    expect_window(512, 200, 1'b0, "R4 negative polarity low count");
    expect_window(512, 312, 1'b1, "R4 negative polarity high count");

    // R5 disabled levels
    write_reg(1'b0, ctl(0, 1, 1));
    repeat (4) @(negedge clk);
    expect_window(512, 0, 1'b1, "R5 disabled positive stays low");
    write_reg(1'b0, ctl(0, 0, 1));
    repeat (4) @(negedge clk);
    expect_window(512, 0, 1'b0, "R5 disabled negative stays high");

    // R5/R6 enable start and deferred duty update
    write_reg(1'b0, ctl(0, 1, 0));
    write_reg(1'b1, 8'd100);
    repeat (5) @(negedge clk);
    write_reg(1'b0, ctl(1, 1, 0));
    hi_run = 0; lo_run = 0; hi2_run = 0; first_lvl = 1'b0;
    fork
      begin
        @(negedge clk);
        first_lvl = pwm_out;
        while (pwm_out == 1'b1 && hi_run < 1000) begin hi_run++; @(negedge clk); end
        while (pwm_out == 1'b0 && lo_run < 1000) begin lo_run++; @(negedge clk); end
        while (pwm_out == 1'b1 && hi2_run < 1000) begin hi2_run++; @(negedge clk); end
      end
      begin
        repeat (40) @(negedge clk);
        write_reg(1'b1, 8'd10);
      end
    join
    check("R5 active one clock after enable", int'(first_lvl), 1);
    check("R5 R6 first run duty*div", hi_run, 100);
    check("R6 rest of old period", lo_run, 156);
    check("R6 new duty after wrap", hi2_run, 10);

    // R7 duty extremes
    write_reg(1'b1, 8'd0);
    settle(1);
    expect_window(256, 0, 1'b1, "R7 duty zero inactive");
    write_reg(1'b1, 8'd255);
    settle(1);
    expect_window(256, 255, 1'b1, "R7 duty full scale");

    summary();
  end
endmodule